// File: doc/BRIEF.md
# Receive Character Store with Error Status

This block sits between a serial receiver's bit sampler and a register interface. Each time the receiver finishes a character, it presents the byte and three error flags on a push strobe. The block stores them as one 12-bit entry. The entry holds the byte in its low eight bits. Above the byte it holds framing, parity, break and overrun flags. The overrun flag is supplied by the block itself.

Software reads characters through a data-read strobe. The same read loads a separate 4-bit status register with the error flags of the character just read. The overrun flag in that register is the exception: it rises as soon as a character is lost, without waiting for a read. A write strobe to the error-clear location empties the status register.

A mode input selects the storage. In queue mode the store is a first-in first-out buffer of `DEPTH` entries. In single mode it is one holding register. Empty and full flags report the state of whichever storage is active.

Top module: `rx_char_store`

## Requirements
- R1: The read word `rd_word` carries the byte in bits 7:0, framing error in bit 8, parity error in bit 9, break error in bit 10 and overrun in bit 11. It is updated on the clock edge that accepts a data read.
- R2: The status output `stat` carries framing in bit 0, parity in bit 1, break in bit 2 and overrun in bit 3.
- R3: Status bits 2:0 change only on a data read that finds a character, or on an error clear. A read loads them with bits 10:8 of the character being read.
- R4: A push that arrives while the store is full, with no accepted read in the same cycle, sets status bit 3 on that same clock edge. No data read is needed.
- R5: A push that arrives while full, with no accepted read, is dropped, and the stored characters stay as they were. The next character that is accepted is stored with bit 11 set.
- R6: With `queue_en`=1, up to `DEPTH` characters are held and read back in arrival order. `rx_full` is 1 exactly when `DEPTH` characters are held.
- R7: With `queue_en`=0, storage is a single holding register. `rx_full` becomes 1 once one character is held.
- R8: A data read while empty leaves `rd_word` and `stat` unchanged.
- R9: An error-clear strobe sets all four status bits to 0. The exception is an overrun in the same cycle: it still sets bit 3.
- R10: After reset, `stat` is 0, `rd_word` is 0, `rx_empty` is 1 and `rx_full` is 0.
- R11: A push together with a data read while full is accepted, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| queue_en | input | 1 | 1 selects queue storage, 0 selects the single holding register |
| push_valid | input | 1 | Receiver delivers one character this cycle |
| push_data | input | 8 | Received byte |
| push_frm | input | 1 | Framing error of the delivered character |
| push_par | input | 1 | Parity error of the delivered character |
| push_brk | input | 1 | Break condition of the delivered character |
| data_rd | input | 1 | Data-register read strobe |
| err_clr | input | 1 | Error-clear write strobe |
| rd_word | output | 12 | Last character read, together with its flags |
| stat | output | 4 | Status register |
| rx_empty | output | 1 | No character is held |
| rx_full | output | 1 | Active storage is full |

## Verification
The assertions check the following on every cycle:
- empty and full are never both asserted;
- an overrun sets status bit 3 on the following edge;
- a clear empties the status register;
- status bits 2:0 stay put between reads and clears;
- after a read, status bits 2:0 match the flags of the character read;
- a read while empty leaves the read word untouched;
- a read paired with a push on a full store leaves it full.

Some behaviour needs a reference model of the stored contents, so only the bench scenarios can show it:
- first-in first-out order across a full queue;
- that dropped characters are really absent;
- that the overrun mark lands on the next accepted character;
- the exact bit placement for every combination of error flags.

// File: rtl/rx_store_pkg.sv
// Shared types for the receive character store.
// Assumes: one received character is a byte plus three receiver flags,
// and the store itself supplies the overrun flag.
package rx_store_pkg;

    // Stored entry. Packed so that bit 11 is overrun, 10 break, 9 parity,
    // 8 framing and 7:0 the data byte.
    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
    localparam int STAT_W  = 4;

endpackage

// File: rtl/rx_entry_queue.sv
// Character storage for the receive store.
// In queue mode it holds up to DEPTH entries, first-in first-out.
// In single mode it holds at most one entry.
// Assumes: wr_en is raised only when there is room or a pop happens in the
// same cycle; rd_en is raised only when not empty; queue_en changes only
// while empty.
module rx_entry_queue
    import rx_store_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      queue_en,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      rd_en,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP_QUEUE = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_SINGLE = CW'(1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;

    // Capacity follows the selected mode.
    always_comb cap = queue_en ? CAP_QUEUE : CAP_SINGLE;

    // Flags come from the occupancy count.
    always_comb begin
        empty = (count == '0);
        full  = (count >= cap);
    end

    // The oldest entry is always visible at the head.
    always_comb head = mem[rd_ptr];

    // One write-enabled register per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Captures the incoming entry when this slot is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_ptr == AW'(g))) begin
                mem[g] <= wr_entry;
            end
        end
    end

    // Advances the write pointer and wraps it at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + AW'(1);
        end
    end

    // Advances the read pointer and wraps it at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_en) begin
            rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + AW'(1);
        end
    end

    // Tracks how many entries are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rx_push_ctrl.sv
// Decides whether an incoming character is stored or lost.
// When one is lost it flags the overrun and marks the next stored character.
// Assumes: full describes the storage before this cycle's pop.
module rx_push_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic push_valid,
    input  logic full,
    input  logic pop,
    output logic wr_en,
    output logic ovr_evt,
    output logic ovr_mark
);

    logic room;
    logic pend_q;

    // A pop in the same cycle frees the slot that the push needs.
    always_comb begin
        room     = !full || pop;
        wr_en    = push_valid && room;
        ovr_evt  = push_valid && !room;
        ovr_mark = pend_q;
    end

    // Remembers a lost character until the next one is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ovr_evt) begin
            pend_q <= 1'b1;
        end else if (wr_en) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_status_reg.sv
// Status register of the receive store.
// Bits 2:0 are loaded from the character being read; bit 3 is a sticky overrun.
// Assumes: load is raised only for a read that returns a character.
module rx_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] load_flags,
    input  logic       ovr_set,
    input  logic       clr,
    output logic [3:0] stat
);

    // Clear takes priority over a load for bits 2:0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat[2:0] <= '0;
        end else if (clr) begin
            stat[2:0] <= '0;
        end else if (load) begin
            stat[2:0] <= load_flags;
        end
    end

    // An overrun in the same cycle takes priority over a clear for bit 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat[3] <= 1'b0;
        end else begin
            stat[3] <= ovr_set || (stat[3] && !clr);
        end
    end

endmodule

// File: rtl/rx_char_store.sv
// Receive character store: keeps received characters and their error flags,
// and presents them through a data read, a status register and an error clear.
// Assumes: the strobes are single-cycle and synchronous to clk, and queue_en
// changes only while the store is empty.
module rx_char_store
    import rx_store_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               queue_en,
    input  logic               push_valid,
    input  logic [7:0]         push_data,
    input  logic               push_frm,
    input  logic               push_par,
    input  logic               push_brk,
    input  logic               data_rd,
    input  logic               err_clr,
    output logic [ENTRY_W-1:0] rd_word,
    output logic [STAT_W-1:0]  stat,
    output logic               rx_empty,
    output logic               rx_full
);

    rx_entry_t wr_entry;
    rx_entry_t head;
    logic      pop;
    logic      wr_en;
    logic      ovr_evt;
    logic      ovr_mark;

    // A read only takes effect when a character is held.
    always_comb pop = data_rd && !rx_empty;

    // Builds the stored entry from the receiver flags and the pending overrun mark.
    always_comb begin
        wr_entry.ovr  = ovr_mark;
        wr_entry.brk  = push_brk;
        wr_entry.par  = push_par;
        wr_entry.frm  = push_frm;
        wr_entry.data = push_data;
    end

    rx_push_ctrl i_push (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .full       (rx_full),
        .pop        (pop),
        .wr_en      (wr_en),
        .ovr_evt    (ovr_evt),
        .ovr_mark   (ovr_mark)
    );

    rx_entry_queue #(.DEPTH(DEPTH)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .queue_en (queue_en),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_en    (pop),
        .head     (head),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    rx_status_reg i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pop),
        .load_flags ({head.brk, head.par, head.frm}),
        .ovr_set    (ovr_evt),
        .clr        (err_clr),
        .stat       (stat)
    );

    // Holds the last character read; a read while empty leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (pop) begin
            rd_word <= head;
        end
    end

endmodule

// File: rtl/rx_char_store_chk.sv
// Port-level checker for the receive character store, bound to every instance.
module rx_char_store_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        queue_en,
    input logic        push_valid,
    input logic        data_rd,
    input logic        err_clr,
    input logic [11:0] rd_word,
    input logic [3:0]  stat,
    input logic        rx_empty,
    input logic        rx_full
);

    assert_empty_full_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    assert_ovr_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rx_full && !data_rd) |=> stat[3]);

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(push_valid && rx_full && !data_rd)) |=> (stat == 4'd0));

    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd && !err_clr) |=> $stable(stat[2:0]));

    assert_flags_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_empty && !err_clr) |=> (stat[2:0] == rd_word[10:8]));

    assert_rd_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_empty) |=> $stable(rd_word));

    assert_single_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_en && push_valid && rx_empty) |=> (rx_full || queue_en));

    assert_swap_keeps_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && data_rd && rx_full) |=> (rx_full || !$stable(queue_en)));

endmodule

bind rx_char_store rx_char_store_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_en   (queue_en),
    .push_valid (push_valid),
    .data_rd    (data_rd),
    .err_clr    (err_clr),
    .rd_word    (rd_word),
    .stat       (stat),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full)
);

// File: tb/test_rx_char_store.sv
module test_rx_char_store;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        queue_en = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        push_frm = 1'b0;
    logic        push_par = 1'b0;
    logic        push_brk = 1'b0;
    logic        data_rd = 1'b0;
    logic        err_clr = 1'b0;
    logic [11:0] rd_word;
    logic [3:0]  stat;
    logic        rx_empty;
    logic        rx_full;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model
    logic [11:0] mq[$];
    logic [11:0] m_rd = '0;
    logic [3:0]  m_stat = '0;
    logic        m_pend = 1'b0;

    always #2.5 clk = ~clk;

    rx_char_store #(.DEPTH(DEPTH)) i_rx_char_store (
        .clk(clk), .rst_n(rst_n), .queue_en(queue_en),
        .push_valid(push_valid), .push_data(push_data),
        .push_frm(push_frm), .push_par(push_par), .push_brk(push_brk),
        .data_rd(data_rd), .err_clr(err_clr),
        .rd_word(rd_word), .stat(stat), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic cmp(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        int cap;
        cap = queue_en ? DEPTH : 1;
        cmp(req, "rd_word", rd_word, m_rd);
        cmp(req, "stat", {8'h0, stat}, {8'h0, m_stat});
        cmp(req, "rx_empty", {11'h0, rx_empty}, {11'h0, (mq.size() == 0)});
        cmp(req, "rx_full", {11'h0, rx_full}, {11'h0, (mq.size() >= cap)});
    endtask

    // One cycle of stimulus, applied at a falling edge, followed by a model update and a check.
    task automatic op(input bit p, input logic [7:0] d, input logic [2:0] fl,
                      input bit rd, input bit clr, input string req);
        int  cap;
        bit  full_m;
        bit  fire;
        bit  ovrset;
        logic [11:0] e;
        cap = queue_en ? DEPTH : 1;
        full_m = (mq.size() >= cap);
        fire = rd && (mq.size() > 0);
        push_valid = p; push_data = d;
        push_frm = fl[0]; push_par = fl[1]; push_brk = fl[2];
        data_rd = rd; err_clr = clr;
        @(negedge clk);
        push_valid = 0; data_rd = 0; err_clr = 0;
        e = '0;
        ovrset = 0;
        if (fire) begin
            e = mq.pop_front();
            m_rd = e;
        end
        if (p) begin
            if (!full_m || fire) begin
                mq.push_back({m_pend, fl[2], fl[1], fl[0], d});
                m_pend = 0;
            end else begin
                m_pend = 1;
                ovrset = 1;
            end
        end
        if (clr) m_stat[2:0] = 3'b000;
        else if (fire) m_stat[2:0] = e[10:8];
        m_stat[3] = ovrset | (m_stat[3] & ~clr);
        chk_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R10");

        // Single holding register: sweep all flag combinations (R7, R1, R2, R3, R4, R5).
        queue_en = 1'b0;
        for (int f = 0; f < 8; f++) begin
            op(1, 8'(f * 37 + 5), 3'(f), 0, 0, "R7");
            op(1, 8'hA5, 3'(7 - f), 0, 0, "R4");
            op(0, 8'h00, 3'b000, 0, 0, "R5");
            op(0, 8'h00, 3'b000, 1, 0, "R1");
            op(0, 8'h00, 3'b000, 1, 0, "R8");
            op(1, 8'(f * 11), 3'(f), 0, 0, "R5");
            op(0, 8'h00, 3'b000, 1, 0, "R2");
            op(0, 8'h00, 3'b000, 0, 1, "R9");
        end
        // Read and push together on a full holding register.
        op(1, 8'h3C, 3'b010, 0, 0, "R7");
        op(1, 8'hC3, 3'b101, 1, 0, "R11");
        op(0, 8'h00, 3'b000, 1, 0, "R11");

        // Queue mode: fill, overflow, swap, drain in order.
        queue_en = 1'b1;
        op(0, 8'h00, 3'b000, 0, 1, "R9");
        for (int i = 0; i < DEPTH; i++) begin
            op(1, 8'(i * 17 + 3), 3'(i % 8), 0, 0, "R6");
        end
        op(1, 8'hEE, 3'b111, 0, 0, "R4");
        op(1, 8'hDD, 3'b011, 0, 0, "R5");
        op(1, 8'h77, 3'b100, 1, 0, "R11");
        for (int i = 0; i < DEPTH; i++) begin
            op(0, 8'h00, 3'b000, 1, 0, "R6");
        end
        op(0, 8'h00, 3'b000, 1, 0, "R8");
        op(1, 8'h42, 3'b001, 0, 0, "R5");
        op(0, 8'h00, 3'b000, 1, 0, "R1");

        // Clear against an overrun in the same cycle.
        queue_en = 1'b0;
        op(1, 8'h11, 3'b110, 0, 0, "R7");
        op(1, 8'h22, 3'b001, 0, 1, "R9");
        op(0, 8'h00, 3'b000, 0, 1, "R9");
        op(0, 8'h00, 3'b000, 1, 0, "R3");
        op(0, 8'h00, 3'b000, 0, 0, "R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule